// File: doc/BRIEF.md
# Address-Pattern Bank Select Controller

This block chooses one of sixteen memory banks, or switches all of them off, with no register write. Each time the active-low chip-enable input falls, it captures one 4-bit nibble from the address lanes. It checks that nibble against a fixed sixteen-step unlock sequence.

Lane 0 works in two ways. In the early steps it carries part of the key. In the last five steps it carries an enable flag and then a 4-bit bank number. When all sixteen consecutive nibbles match, the new selection is applied on the rising edge of the chip-enable input that closes the sixteenth cycle.

After the commit, the bank select outputs hold that bank. The chip-enable output either follows the chip-enable input, or is forced inactive when the banks are switched off.

The chip-enable input is synchronized to the system clock and edge-detected before it reaches the matcher. The gating from the chip-enable input to the chip-enable output is purely combinational.

Top module: `bank_select_ctrl`

## Requirements
- R1: While rst_n is low and after it is released, bank_sel is 0 and cen_out is 1, whatever the level of cen_in.
- R2: Exactly one nibble is captured per falling edge of cen_in. Sixteen consecutive matching nibbles select a bank. Lane bits are adr_nib[0]=lane 0, adr_nib[1]=lane 1, adr_nib[2]=lane 2 and adr_nib[3]=lane 3. Listed from step 0 to step 15, lane 1 must be 0101110010100011, lane 2 must be 1010001101011100, and lane 3 must be the same as lane 1.
- R3: On lane 0, steps 0 to 10 must be 10100011010. Step 11 is the enable flag. Steps 12 to 15 are the bank number, most significant bit first. With the flag at 1, bank_sel[0] is the bank LSB and bank_sel[3] is its MSB, so bank 0 drives bank_sel to 0.
- R4: If the flag at step 11 is 0, the sequence switches the banks off. bank_sel becomes 0, cen_out stays 1 even while cen_in is low, and the lane 0 bits of steps 12 to 15 are ignored.
- R5: While a bank is selected, cen_out equals cen_in combinationally.
- R6: A completed sequence changes nothing until cen_in rises at the end of the sixteenth cycle. While cen_in is still low in that cycle, the old bank_sel and cen_out behaviour remain.
- R7: bank_sel keeps its value through any number of later chip-enable cycles until another complete sequence commits.
- R8: A nibble that does not match the current step sends the step count back to 0 and leaves the outputs unchanged. If that nibble equals the step 0 nibble, it is counted as step 0.
- R9: A nibble of all ones (4'hF) realigns the matcher, so the next nibble is compared with step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-fail condition) |
| cen_in | input | 1 | Active-low chip-enable from the host |
| adr_nib | input | 4 | Address lanes sampled on each chip-enable fall |
| bank_sel | output | 4 | Bank select lines, bit 0 is the bank LSB |
| cen_out | output | 1 | Gated active-low chip-enable to the memory |

## Verification
The assertions assume that cen_in stays at each level for at least three clock cycles, so every transition passes the synchronizer and is seen as exactly one edge. They also assume that adr_nib is stable around each falling edge. The stimulus changes adr_nib only while cen_in is high and holds each level of cen_in for four clocks. With this timing, every nibble lands in the matcher once, and the commit falls on the first clock after the synchronized rise.

// File: rtl/bsel_pkg.sv
// Package: constants of the unlock sequence and helpers that give the
// expected nibble and the comparison mask for a step. Assumes a fixed
// sequence of STEPS nibbles whose final BANK_W+1 lane 0 bits are data.
package bsel_pkg;

    localparam int STEPS     = 16;
    localparam int NIB_W     = 4;
    localparam int BANK_W    = 4;
    localparam int FLAG_STEP = STEPS - BANK_W - 1;
    localparam int STEP_W    = $clog2(STEPS);

    // Per-lane key bits, step 0 in the most significant position.
    localparam logic [STEPS-1:0]     LANE1_KEY = 16'b0101110010100011;
    localparam logic [STEPS-1:0]     LANE2_KEY = 16'b1010001101011100;
    localparam logic [STEPS-1:0]     LANE3_KEY = LANE1_KEY;
    localparam logic [FLAG_STEP-1:0] LANE0_KEY = 11'b10100011010;

    // Expected nibble for a step (lane 0 is zero where it carries data).
    function automatic logic [NIB_W-1:0] key_nib(input logic [STEP_W-1:0] s);
        logic [NIB_W-1:0] n;
        int idx;
        idx  = STEPS - 1 - int'(s);
        n[1] = LANE1_KEY[idx];
        n[2] = LANE2_KEY[idx];
        n[3] = LANE3_KEY[idx];
        n[0] = 1'b0;
        if (int'(s) < FLAG_STEP) begin
            n[0] = LANE0_KEY[FLAG_STEP - 1 - int'(s)];
        end
        return n;
    endfunction

    // Lanes compared at a step: lane 0 only while it is part of the key.
    function automatic logic [NIB_W-1:0] key_mask(input logic [STEP_W-1:0] s);
        logic [NIB_W-1:0] m;
        m = '1;
        if (int'(s) >= FLAG_STEP) begin
            m[0] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/bsel_edge_sync.sv
// Synchronizes the asynchronous active-low chip-enable into the clock
// domain and produces one-cycle pulses for its falling and rising edges.
// Assumes each input level lasts longer than SYNC_STAGES+1 clock cycles.
module bsel_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // First stage of the synchronizer, resets to the inactive (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= async_i;
    end

    // Remaining stages of the synchronizer chain.
    genvar g;
    generate
        for (g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    // Edge pulses, each one cycle wide.
    always_comb begin
        fall_o = last_q & ~chain_q[SYNC_STAGES-1];
        rise_o = ~last_q & chain_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/bsel_matcher.sv
// Step matcher: on each chip-enable fall it compares the address nibble
// with the expected nibble of the current step, collects the enable
// flag and bank bits, and arms a commit that fires on the next rise.
// Assumes fall and rise pulses alternate and adr is stable at the fall.
module bsel_matcher
    import bsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic              commit_o,
    output logic              en_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [STEP_W-1:0] step_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
    localparam logic [STEP_W-1:0] FLAG_IDX  = STEP_W'(FLAG_STEP);

    logic [STEP_W-1:0] step_q;
    logic              flag_q;
    logic [BANK_W-1:0] bank_sh_q;
    logic              armed_q;

    logic              hit;
    logic              hit_first;
    logic              realign;

    // Compare the nibble with the current step and with step 0.
    always_comb begin
        hit       = ((nib_i ^ key_nib(step_q)) & key_mask(step_q)) == '0;
        hit_first = nib_i == key_nib('0);
        realign   = &nib_i;
    end

    // Step counter and arming of a completed sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            armed_q <= 1'b0;
        end else if (fall_i) begin
            if (realign) begin
                step_q  <= '0;
                armed_q <= 1'b0;
            end else if (hit) begin
                if (step_q == LAST_STEP) begin
                    step_q  <= '0;
                    armed_q <= 1'b1;
                end else begin
                    step_q  <= step_q + 1'b1;
                    armed_q <= 1'b0;
                end
            end else begin
                step_q  <= hit_first ? STEP_W'(1) : '0;
                armed_q <= 1'b0;
            end
        end else if (rise_i) begin
            armed_q <= 1'b0;
        end
    end

    // Capture the enable flag and shift in the bank bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q    <= 1'b0;
            bank_sh_q <= '0;
        end else if (fall_i && hit && !realign) begin
            if (step_q == FLAG_IDX) begin
                flag_q <= nib_i[0];
            end else if (step_q > FLAG_IDX) begin
                bank_sh_q <= {bank_sh_q[BANK_W-2:0], nib_i[0]};
            end
        end
    end

    // Outputs to the bank register.
    always_comb begin
        commit_o = armed_q & rise_i;
        en_o     = flag_q;
        bank_o   = bank_sh_q;
        step_o   = step_q;
    end

endmodule

// File: rtl/bsel_bank_reg.sv
// Bank register and output gate: holds the selected bank and enable,
// loads them only on a commit, clears the bank when switched off, and
// gates the chip-enable combinationally. Assumes commit is a single pulse.
module bsel_bank_reg
    import bsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              en_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              cen_in,
    output logic [BANK_W-1:0] bank_sel,
    output logic              cen_out,
    output logic              en_o
);

    logic              en_q;
    logic [BANK_W-1:0] bank_q;

    // Load a new selection on commit; banks off stores bank 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            bank_q <= '0;
        end else if (commit_i) begin
            en_q   <= en_i;
            bank_q <= en_i ? bank_i : '0;
        end
    end

    // Drive the select lines and gate the chip-enable.
    always_comb begin
        bank_sel = bank_q;
        cen_out  = en_q ? cen_in : 1'b1;
        en_o     = en_q;
    end

endmodule

// File: rtl/bank_select_ctrl.sv
// Top level: address-pattern bank select controller. Chains the edge
// synchronizer, the sequence matcher and the bank register. Assumes
// cen_in levels last several clocks and adr_nib is stable at each fall.
module bank_select_ctrl
    import bsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_in,
    input  logic [NIB_W-1:0]  adr_nib,
    output logic [BANK_W-1:0] bank_sel,
    output logic              cen_out
);

    logic              cen_fall;
    logic              cen_rise;
    logic              commit;
    logic              seq_en;
    logic [BANK_W-1:0] seq_bank;
    logic [STEP_W-1:0] seq_step;
    logic              bank_en;

    bsel_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cen_in),
        .fall_o (cen_fall),
        .rise_o (cen_rise)
    );

    bsel_matcher u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (cen_fall),
        .rise_i  (cen_rise),
        .nib_i   (adr_nib),
        .commit_o(commit),
        .en_o    (seq_en),
        .bank_o  (seq_bank),
        .step_o  (seq_step)
    );

    bsel_bank_reg u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit),
        .en_i    (seq_en),
        .bank_i  (seq_bank),
        .cen_in  (cen_in),
        .bank_sel(bank_sel),
        .cen_out (cen_out),
        .en_o    (bank_en)
    );

endmodule

// File: rtl/bsel_checker.sv
// Checker for bank_select_ctrl: relates edge pulses, matcher state and
// the output register over time. Bound to the top module below.
module bsel_checker
    import bsel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cen_out,
    input logic [BANK_W-1:0] bank_sel,
    input logic [NIB_W-1:0]  adr_nib,
    input logic              cen_fall,
    input logic              cen_rise,
    input logic              commit,
    input logic              bank_en,
    input logic [STEP_W-1:0] seq_step
);

    // R1: reset leaves the banks off and the enable output inactive.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (bank_sel == '0 && cen_out));

    // R4: with banks off the select lines are low and cen_out is high.
    p_off_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_en |-> (bank_sel == '0 && cen_out));

    // R6: a commit only happens with a synchronized rising edge.
    p_commit_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cen_rise);

    // R7: the select lines change only in the cycle after a commit.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(bank_sel));

    // R9: an all-ones nibble returns the matcher to step 0.
    p_realign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_fall && adr_nib == '1) |=> seq_step == '0);

    // R2: rise and fall pulses never coincide.
    p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cen_fall && cen_rise));

endmodule

bind bank_select_ctrl bsel_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen_out (cen_out),
    .bank_sel(bank_sel),
    .adr_nib (adr_nib),
    .cen_fall(cen_fall),
    .cen_rise(cen_rise),
    .commit  (commit),
    .bank_en (bank_en),
    .seq_step(seq_step)
);

// File: tb/tb_bank_select_ctrl.sv
`timescale 1ns/1ps
module tb_bank_select_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cen_in = 1'b1;
    logic [3:0] adr_nib = 4'h0;
    logic [3:0] bank_sel;
    logic       cen_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bank_select_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cen_in  (cen_in),
        .adr_nib (adr_nib),
        .bank_sel(bank_sel),
        .cen_out (cen_out)
    );

    // Key bits from the requirements, step 0 leftmost.
    localparam logic [15:0] K1 = 16'b0101110010100011;
    localparam logic [15:0] K2 = 16'b1010001101011100;
    localparam logic [10:0] K0 = 11'b10100011010;

    typedef struct {
        logic [3:0] bs;
        logic       on;
        string      req;
    } exp_t;

    exp_t sb[$];

    function automatic logic [3:0] seq_nib(int s, logic en, logic [3:0] bank);
        logic w;
        if (s < 11)       w = K0[10 - s];
        else if (s == 11) w = en;
        else              w = bank[15 - s];
        return {K1[15 - s], K2[15 - s], K1[15 - s], w};
    endfunction

    // Driver side of the scoreboard: push an expectation, wait for the monitor.
    task automatic expect_state(logic [3:0] bs, logic on, string req);
        exp_t e;
        e.bs = bs; e.on = on; e.req = req;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    // One chip-enable cycle; optionally checks the outputs while cen_in is low.
    task automatic nib_cycle(logic [3:0] n, bit chk, logic [3:0] bs, logic on, string req);
        @(posedge clk); #1;
        adr_nib = n;
        repeat (2) @(posedge clk);
        #1 cen_in = 1'b0;
        repeat (4) @(posedge clk);
        if (chk) expect_state(bs, on, req);
        @(posedge clk); #1 cen_in = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic send_steps(int first, int last, logic en, logic [3:0] bank);
        for (int s = first; s <= last; s++) nib_cycle(seq_nib(s, en, bank), 0, 4'h0, 0, "");
    endtask

    // Full sequence; the last cycle checks the old state before the rise (R6).
    task automatic unlock(logic en, logic [3:0] bank, logic [3:0] old_bs, logic old_on);
        send_steps(0, 14, en, bank);
        nib_cycle(seq_nib(15, en, bank), 1, old_bs, old_on, "R6");
    endtask

    // Monitor: pops expectations and compares away from the active edge.
    initial begin
        exp_t e;
        logic exp_ce;
        forever begin
            wait (sb.size() != 0);
            @(negedge clk);
            e = sb[0];
            exp_ce = e.on ? cen_in : 1'b1;
            n_run++;
            if (bank_sel !== e.bs) begin
                n_fail++;
                $display("FAIL %s bank_sel actual=%h expected=%h", e.req, bank_sel, e.bs);
            end
            n_run++;
            if (cen_out !== exp_ce) begin
                n_fail++;
                $display("FAIL %s cen_out actual=%b expected=%b", e.req, cen_out, exp_ce);
            end
            void'(sb.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] lfsr;
        repeat (4) @(posedge clk);
        expect_state(4'h0, 0, "R1");
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        expect_state(4'h0, 0, "R1");
        nib_cycle(4'h0, 1, 4'h0, 0, "R1");

        // R2 R3: unlock bank 5 after a realign nibble.
        nib_cycle(4'hF, 0, 4'h0, 0, "");
        unlock(1, 4'd5, 4'h0, 0);
        expect_state(4'd5, 1, "R2");
        nib_cycle(4'h0, 1, 4'd5, 1, "R5");

        // R3: other bank numbers, including bank 0 enabled.
        unlock(1, 4'd10, 4'd5, 1);
        expect_state(4'd10, 1, "R3");
        unlock(1, 4'd0, 4'd10, 1);
        nib_cycle(4'h0, 1, 4'd0, 1, "R3");

        // R4: banks off with bank bits all ones.
        unlock(0, 4'hF, 4'd0, 1);
        expect_state(4'h0, 0, "R4");
        nib_cycle(4'h0, 1, 4'h0, 0, "R4");

        unlock(1, 4'd3, 4'h0, 0);
        expect_state(4'd3, 1, "R3");

        // R8: an aborted sequence does not unlock when continued.
        send_steps(0, 7, 1, 4'd12);
        nib_cycle(4'h0, 1, 4'd3, 1, "R8");
        send_steps(8, 15, 1, 4'd12);
        expect_state(4'd3, 1, "R8");

        // R8: a mismatching nibble equal to step 0 is counted as step 0.
        nib_cycle(4'hF, 0, 4'h0, 0, "");
        send_steps(0, 4, 1, 4'd9);
        nib_cycle(seq_nib(0, 1, 4'd9), 0, 4'h0, 0, "");
        send_steps(1, 14, 1, 4'd9);
        nib_cycle(seq_nib(15, 1, 4'd9), 1, 4'd3, 1, "R6");
        expect_state(4'd9, 1, "R8");

        // R9: all-ones mid-sequence realigns to step 0.
        send_steps(0, 6, 1, 4'd6);
        nib_cycle(4'hF, 1, 4'd9, 1, "R9");
        unlock(1, 4'd6, 4'd9, 1);
        expect_state(4'd6, 1, "R9");

        // R7: plain memory cycles leave the selection alone.
        lfsr = 4'h9;
        for (int i = 0; i < 20; i++) begin
            lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
            nib_cycle(lfsr, 1, 4'd6, 1, "R7");
        end

        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule